// File: doc/BRIEF.md
# Firmware Entry Vector and Interrupt Arbiter

This block decides, once per clock, whether the processor enters firmware, and at which address. A synchronous exception request, or a call into firmware with an 8-bit service code, always enters firmware. Otherwise the block looks at four pending interrupt lines. Each line is qualified by the 3-bit priority level from the processor status and by the current firmware-mode flag. If any line survives, the one with the highest priority wins.

When an entry is taken, the registered outputs update together on the next clock edge. The new PC is the firmware base plus the entry offset. The saved exception address is the current PC with the firmware-mode bit in bit 0. The mode flag becomes set, and the error code is loaded. On a cycle with no entry, the PC and mode outputs follow the current values, while the saved address and the error code hold. The surrounding pipeline presents its architectural PC and mode at the inputs, and takes the outputs as its next state whenever `take_o` is high.

Top module: `fw_vector_arb`

## Requirements
- R1: While `rst_n` is low, `take_o`, `new_pc_o`, `saved_pc_o`, `fw_mode_o` and `err_o` are all zero.
- R2: When `cur_fw_i` is 1 and no valid exception is requested, no interrupt is taken (`take_o` is 0 in the next cycle).
- R3: Interrupt lines are `irq_i[0]`=device, `[1]`=timer, `[2]`=inter-processor, `[3]`=machine-check. At level 0 to 3 all four are eligible. Level 4 drops device. Level 5 also drops timer. Level 6 leaves machine-check only. Level 7 masks all four.
- R4: Among eligible lines, machine-check wins over inter-processor, inter-processor wins over timer, and timer wins over device.
- R5: A taken interrupt uses offset 0x080 for machine-check, 0x100 for inter-processor, 0x180 for timer and 0x200 for device, and sets `err_o` to 0.
- R6: `exc_kind_i` values 0 to 9 mean reset, machine-check, inter-processor, timer, device, memory fault, unaligned, illegal opcode, arithmetic and FP-disabled. Kind k uses offset k*0x80, and `err_o` takes `exc_code_i`.
- R7: Kind 10 is a call into firmware. When code bit 7 is set, the offset is 0x2000 + (code-0x80)*64. Otherwise the offset is 0x1000 + code*64.
- R8: One cycle after a taken entry, `take_o`=1, `new_pc_o` = `fw_base_i` + offset, `saved_pc_o` = `cur_pc_i` | `cur_fw_i`, and `fw_mode_o`=1. All input values are taken from the entry cycle.
- R9: A valid exception in the same cycle as an eligible interrupt takes the exception. This holds even in firmware mode.
- R10: `exc_kind_i` values 11 to 15 are ignored, and the cycle behaves as if no exception were requested.
- R11: On a cycle with no entry, `take_o`=0, `new_pc_o`=`cur_pc_i` and `fw_mode_o`=`cur_fw_i`, one cycle later. `saved_pc_o` and `err_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 4 | Pending interrupts: device, timer, inter-processor, machine-check |
| exc_req_i | input | 1 | Exception request |
| exc_kind_i | input | 4 | Exception kind, 10 = call into firmware |
| exc_code_i | input | CODE_W | Error or service code |
| cur_pc_i | input | PC_W | Current PC |
| cur_fw_i | input | 1 | Current firmware-mode flag |
| fw_base_i | input | PC_W | Firmware base address |
| ipl_i | input | 3 | Status priority level |
| take_o | output | 1 | Entry taken last cycle |
| new_pc_o | output | PC_W | Next PC |
| saved_pc_o | output | PC_W | Saved exception address |
| fw_mode_o | output | 1 | Next firmware-mode flag |
| err_o | output | CODE_W | Error code |

## Verification
An exception request and an eligible interrupt can arrive in the same cycle, and the arbitration between them is the main risk. The bench drives both together at every priority level, with the firmware flag both clear and set. A behavioural model then judges each clock. The check is that the exception's offset and code appear, and that no interrupt offset or zero error code does. Level boundaries 3/4, 4/5, 5/6 and 6/7 are stepped through with all four lines pending, and also with each line pending alone.

// File: rtl/fw_vector_arb.sv
module fw_vector_arb #(
  parameter int PC_W   = 64,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        irq_i,
  input  logic              exc_req_i,
  input  logic [3:0]        exc_kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [PC_W-1:0]   cur_pc_i,
  input  logic              cur_fw_i,
  input  logic [PC_W-1:0]   fw_base_i,
  input  logic [2:0]        ipl_i,
  output logic              take_o,
  output logic [PC_W-1:0]   new_pc_o,
  output logic [PC_W-1:0]   saved_pc_o,
  output logic              fw_mode_o,
  output logic [CODE_W-1:0] err_o
);
  localparam int OFF_W = 14;
  localparam logic [3:0] KIND_CALL = 4'd10;

  logic [3:0]        irq_ok, irq_live;
  logic              exc_ok, take_n;
  logic [OFF_W-1:0]  off, call_off;
  logic [CODE_W-1:0] err_n;

  assign irq_ok   = {ipl_i <= 3'd6, ipl_i <= 3'd5, ipl_i <= 3'd4, ipl_i <= 3'd3};
  assign irq_live = irq_i & irq_ok & {4{~cur_fw_i}};
  assign exc_ok   = exc_req_i && (exc_kind_i <= KIND_CALL);
  assign take_n   = exc_ok || (|irq_live);
  assign call_off = (exc_code_i[7] ? 14'h2000 : 14'h1000) + {1'b0, exc_code_i[6:0], 6'b0};

  always_comb begin
    off   = '0;
    err_n = '0;
    if (exc_ok) begin
      err_n = exc_code_i;
      off   = (exc_kind_i == KIND_CALL) ? call_off : {3'b0, exc_kind_i, 7'b0};
    end else if (irq_live[3]) off = 14'h080;
    else if (irq_live[2])     off = 14'h100;
    else if (irq_live[1])     off = 14'h180;
    else if (irq_live[0])     off = 14'h200;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      new_pc_o   <= '0;
      saved_pc_o <= '0;
      fw_mode_o  <= 1'b0;
      err_o      <= '0;
    end else begin
      take_o <= take_n;
      if (take_n) begin
        new_pc_o   <= fw_base_i + PC_W'(off);
        saved_pc_o <= {cur_pc_i[PC_W-1:1], cur_pc_i[0] | cur_fw_i};
        fw_mode_o  <= 1'b1;
        err_o      <= err_n;
      end else begin
        new_pc_o  <= cur_pc_i;
        fw_mode_o <= cur_fw_i;
      end
    end
  end
endmodule

// File: rtl/fw_vector_arb_chk.sv
module fw_vector_arb_chk #(
  parameter int PC_W   = 64,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        irq_i,
  input logic              exc_req_i,
  input logic [3:0]        exc_kind_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic [PC_W-1:0]   cur_pc_i,
  input logic              cur_fw_i,
  input logic [PC_W-1:0]   fw_base_i,
  input logic [2:0]        ipl_i,
  input logic              take_o,
  input logic [PC_W-1:0]   new_pc_o,
  input logic [PC_W-1:0]   saved_pc_o,
  input logic              fw_mode_o,
  input logic [CODE_W-1:0] err_o
);
  assert_fw_blocks_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_fw_i && !(exc_req_i && exc_kind_i <= 4'd10)) |=> !take_o);

  assert_level7_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_i == 3'd7 && !(exc_req_i && exc_kind_i <= 4'd10)) |=> !take_o);

  assert_mchk_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && !cur_fw_i && ipl_i != 3'd7 && irq_i[3])
      |=> (take_o && err_o == '0 && new_pc_o == $past(fw_base_i) + PC_W'(14'h080)));

  assert_exc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && exc_kind_i <= 4'd10) |=> (take_o && err_o == $past(exc_code_i)));

  assert_entry_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_o) |-> (fw_mode_o && saved_pc_o[0] == ($past(cur_pc_i[0]) | $past(cur_fw_i))));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_o && $past(rst_n)) |=> (!take_o |-> $stable(saved_pc_o)));
endmodule

bind fw_vector_arb fw_vector_arb_chk #(.PC_W(PC_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .exc_req_i(exc_req_i),
  .exc_kind_i(exc_kind_i), .exc_code_i(exc_code_i), .cur_pc_i(cur_pc_i),
  .cur_fw_i(cur_fw_i), .fw_base_i(fw_base_i), .ipl_i(ipl_i), .take_o(take_o),
  .new_pc_o(new_pc_o), .saved_pc_o(saved_pc_o), .fw_mode_o(fw_mode_o), .err_o(err_o)
);

// File: tb/test_fw_vector_arb.sv
module test_fw_vector_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq = '0;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_kind = '0;
  logic [7:0]  exc_code = '0;
  logic [63:0] cur_pc = '0;
  logic        cur_fw = 1'b0;
  logic [63:0] fw_base = '0;
  logic [2:0]  ipl = '0;
  logic        take;
  logic [63:0] new_pc, saved_pc;
  logic        fw_mode;
  logic [7:0]  err;

  int checks = 0, errors = 0;
  logic        e_take = 0, e_fw = 0;
  logic [63:0] e_pc = 0, e_saved = 0;
  logic [7:0]  e_err = 0;
  string       tag = "R1";

  always #4 clk = ~clk;

  fw_vector_arb i_fw_vector_arb (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .exc_req_i(exc_req), .exc_kind_i(exc_kind),
    .exc_code_i(exc_code), .cur_pc_i(cur_pc), .cur_fw_i(cur_fw), .fw_base_i(fw_base),
    .ipl_i(ipl), .take_o(take), .new_pc_o(new_pc), .saved_pc_o(saved_pc),
    .fw_mode_o(fw_mode), .err_o(err)
  );

  task automatic check_outputs();
    checks++;
    if (take !== e_take || new_pc !== e_pc || saved_pc !== e_saved ||
        fw_mode !== e_fw || err !== e_err) begin
      errors++;
      $display("FAIL %s: got take=%0b pc=%h saved=%h fw=%0b err=%h exp take=%0b pc=%h saved=%h fw=%0b err=%h",
               tag, take, new_pc, saved_pc, fw_mode, err, e_take, e_pc, e_saved, e_fw, e_err);
    end
  endtask

  task automatic model();
    longint off = -1;
    logic [7:0] code = 0;
    if (!rst_n) begin
      e_take = 0; e_pc = 0; e_saved = 0; e_fw = 0; e_err = 0;
      return;
    end
    if (exc_req && exc_kind < 10) begin off = longint'(exc_kind) * 128; code = exc_code; end
    else if (exc_req && exc_kind == 10) begin
      code = exc_code;
      if (exc_code >= 128) off = 'h2000 + (longint'(exc_code) - 128) * 64;
      else off = 'h1000 + longint'(exc_code) * 64;
    end else if (!cur_fw) begin
      if (irq[3] && ipl <= 6) off = 'h080;
      else if (irq[2] && ipl <= 5) off = 'h100;
      else if (irq[1] && ipl <= 4) off = 'h180;
      else if (irq[0] && ipl <= 3) off = 'h200;
    end
    if (off >= 0) begin
      e_take = 1; e_pc = fw_base + 64'(off); e_saved = cur_pc | 64'(cur_fw);
      e_fw = 1; e_err = code;
    end else begin
      e_take = 0; e_pc = cur_pc; e_fw = cur_fw;
    end
  endtask

  task automatic step(input string t, input logic [3:0] q, input logic er, input logic [3:0] k,
                      input logic [7:0] c, input logic fw, input logic [2:0] lv);
    @(negedge clk);
    check_outputs();
    tag = t; irq = q; exc_req = er; exc_kind = k; exc_code = c; cur_fw = fw; ipl = lv;
    cur_pc = {$urandom, $urandom}; fw_base = {$urandom, $urandom & 32'hFFFF_0000};
    model();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model();
    repeat (3) begin @(negedge clk); tag = "R1"; check_outputs(); end
    rst_n = 1'b1;
    model();
    step("R11", 4'h0, 0, 0, 8'h00, 0, 0);
    step("R11", 4'h0, 0, 0, 8'h00, 1, 0);
    for (int lv = 0; lv < 8; lv++) begin
      step("R3", 4'hF, 0, 0, 0, 0, 3'(lv));
      for (int b = 0; b < 4; b++) step("R3", 4'(1 << b), 0, 0, 0, 0, 3'(lv));
    end
    step("R4", 4'b1100, 0, 0, 0, 0, 0);
    step("R4", 4'b0110, 0, 0, 0, 0, 0);
    step("R4", 4'b0011, 0, 0, 0, 0, 0);
    step("R5", 4'b0001, 0, 0, 8'h55, 0, 2);
    step("R2", 4'hF, 0, 0, 0, 1, 0);
    step("R2", 4'hF, 1, 4'd12, 8'h33, 1, 0);
    for (int k = 0; k < 10; k++) step("R6", 4'h0, 1, 4'(k), 8'(k * 7 + 1), 0, 0);
    foreach (exc_code[i]) begin
      step("R7", 4'h0, 1, 4'd10, 8'(1 << i), 0, 0);
    end
    step("R7", 4'h0, 1, 4'd10, 8'h00, 0, 0);
    step("R7", 4'h0, 1, 4'd10, 8'h7F, 0, 0);
    step("R7", 4'h0, 1, 4'd10, 8'h80, 0, 0);
    step("R7", 4'h0, 1, 4'd10, 8'hFF, 0, 0);
    for (int lv = 0; lv < 8; lv++) begin
      step("R9", 4'hF, 1, 4'd8, 8'hA5, 0, 3'(lv));
      step("R9", 4'hF, 1, 4'd10, 8'h91, 1, 3'(lv));
    end
    for (int k = 11; k < 16; k++) begin
      step("R10", 4'h0, 1, 4'(k), 8'hC3, 0, 0);
      step("R10", 4'h8, 1, 4'(k), 8'hC3, 0, 7);
    end
    step("R8", 4'h0, 1, 4'd5, 8'h10, 1, 0);
    for (int n = 0; n < 3000; n++)
      step("R8", 4'($urandom), ($urandom % 3) == 0, 4'($urandom), 8'($urandom),
           1'($urandom), 3'($urandom));
    @(negedge clk);
    check_outputs();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule